// File: doc/BRIEF.md
# Multi-Mode Protected Register File

This block is a 32-entry, 32-bit register file that chooses its fault protection on every access. Each write and each read carries a 3-bit mode code. The code selects one of five schemes:

- single-error-correcting, double-error-detecting Hamming code (SEC-DED);
- three copies with a majority vote;
- a plain duplicate that can only detect errors;
- a duplicate in which both copies carry SEC-DED check bits;
- raw storage with no protection.

All modes share one array of 39-bit slots. Each mode maps a logical address onto one, two or three slots of that array.

Read results are registered. A 2-bit status returns with the data:

- 00: clean;
- 01: the data is correct, but a fault was seen or repaired;
- 10: an uncorrectable or unresolved fault;
- 11: never produced.

A ready output tells the requester when a new request will be taken. A fault-injection port XORs a mask into any stored slot, so that error handling can be exercised.

Top module: `prot_regfile`

## Requirements
- R1: After reset, `rdata_o` is 0, `status_o` is 00 and `ready_o` is 1, and every slot holds all zeros. An ECC read of any address therefore returns 0 with status 00. `status_o` never shows 11.
- R2: Mode 000 (ECC) uses address bits [4:0] as the slot. The slot stores {overall parity bit 38, Hamming check bits 37:32, data 31:0}. A read of an unmodified slot returns the written data with status 00.
- R3: In mode 000, flipping any single bit of the 39-bit slot (bits 0 to 38) still returns the written data, with status 01.
- R4: In mode 000, flipping any two bits of a slot gives status 10. The returned data is the raw stored bits [31:0], uncorrected.
- R5: Mode 001 (triple) uses address bits [2:0] as index i. It writes the data, zero-extended, to slots i, i+8 and i+16. A read returns the bitwise majority of the three data fields. Status is 00 when all three agree and 01 when exactly one differs.
- R6: In mode 001, when no two of the three copies agree, the status is 10. The bitwise majority is still returned.
- R7: Mode 011 (plain shadow) uses address bits [3:0] as index i. It stores the data, zero-extended, in slots i and i+16. A read returns slot i bits [31:0] uncorrected. Status is 10 if the two data fields differ, else 00.
- R8: Mode 010 (ECC shadow) stores the SEC-DED word in slots i and i+16, where i is address bits [3:0]. A read returns the decoded slot i. The status is set as follows:
  - 10 when the decode finds a double error;
  - 01 when the two 39-bit words differ and the decode finds no double error;
  - otherwise the decode status.
- R9: Mode 100, and the unused codes 101 to 111, store the data zero-extended in slot address[4:0]. A read returns bits [31:0] as stored, with status 00, even when those bits were flipped.
- R10: Read data and status change at the clock edge that accepts the read. `ready_o` is 0 for the one cycle after an accepted read, and for the one cycle after an accepted write in modes 001, 010 or 011. A write in modes 000 or 100 keeps `ready_o` at 1.
- R11: A request is accepted only while `ready_o` is 1. A write or read presented while `ready_o` is 0 has no effect. When `wr_i` and `rd_i` are both high, only the write is performed and the read outputs keep their values.
- R12: When `inj_en_i` is high at a clock edge, slot `inj_slot_i` is XORed with `inj_mask_i`, whatever the state of `ready_o`. An accepted write to the same slot in the same cycle takes precedence, and the mask is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Write request |
| rd_i | input | 1 | Read request |
| addr_i | input | 5 | Logical register address |
| wdata_i | input | 32 | Write data |
| mode_i | input | 3 | Protection mode code |
| rdata_o | output | 32 | Registered read data |
| status_o | output | 2 | Registered read status |
| ready_o | output | 1 | Request can be accepted |
| inj_en_i | input | 1 | Apply fault mask this cycle |
| inj_slot_i | input | 5 | Physical slot to corrupt |
| inj_mask_i | input | 39 | Bits to flip in that slot |

## Verification
Random write/read traffic in each mode, with address high bits also randomized, separates correct mode-specific address folding from aliasing errors. Directed injections then tell apart the fault classes:

- single flips in data and in check bits;
- double flips;
- one or two corrupted copies in the triple and shadow modes;
- identical corruption of both ECC shadow copies.

Each class checks a distinct status code. Cross-mode raw reads of the copy slots prove where the copies land. Writes and reads issued while busy, or together, and a write that collides with an injection, show the acceptance and priority rules at the ports.

// File: rtl/prf_pkg.sv
package prf_pkg;
  parameter int DATA_W     = 32;
  parameter int PAR_W      = 6;
  parameter int HAM_N      = DATA_W + PAR_W;
  parameter int CODE_W     = HAM_N + 1;
  parameter int NUM_SLOTS  = 32;
  parameter int SLOT_W     = $clog2(NUM_SLOTS);
  parameter int NUM_COPIES = 3;

  typedef enum logic [2:0] {
    MODE_ECC     = 3'b000,
    MODE_TMR     = 3'b001,
    MODE_ECC_SHD = 3'b010,
    MODE_SHD     = 3'b011,
    MODE_RAW     = 3'b100
  } mode_e;

  typedef enum logic [1:0] {
    ST_OK    = 2'b00,
    ST_FIXED = 2'b01,
    ST_BAD   = 2'b10,
    ST_RSVD  = 2'b11
  } status_e;

  function automatic logic is_pow2(int p);
    return (p & (p - 1)) == 0;
  endfunction

  // stored layout: {overall parity, check[PAR_W-1:0], data}
  function automatic logic [CODE_W-1:0] secded_enc(logic [DATA_W-1:0] d);
    logic [HAM_N:1]   h;
    logic [PAR_W-1:0] c;
    int j;
    h = '0;
    j = 0;
    for (int p = 1; p <= HAM_N; p++) begin
      if (!is_pow2(p)) begin
        h[p] = d[j];
        j++;
      end
    end
    for (int k = 0; k < PAR_W; k++) begin
      c[k] = 1'b0;
      for (int p = 1; p <= HAM_N; p++)
        if (p[k]) c[k] = c[k] ^ h[p];
    end
    return {^{c, d}, c, d};
  endfunction
endpackage

// File: rtl/prf_secded_dec.sv
module prf_secded_dec
  import prf_pkg::*;
(
  input  logic [CODE_W-1:0] word_i,
  output logic [DATA_W-1:0] data_o,
  output status_e           status_o
);
  localparam logic [PAR_W-1:0] HAM_MAX = PAR_W'(HAM_N);

  logic [PAR_W-1:0] syn;
  logic             par;
  logic             fix;

  always_comb begin
    logic [HAM_N:1] h;
    h = '0;
    begin
      int j;
      j = 0;
      for (int p = 1; p <= HAM_N; p++) begin
        if (!is_pow2(p)) begin
          h[p] = word_i[j];
          j++;
        end
      end
    end
    for (int k = 0; k < PAR_W; k++) h[1 << k] = word_i[DATA_W + k];
    syn = '0;
    for (int p = 1; p <= HAM_N; p++)
      if (h[p]) syn = syn ^ p[PAR_W-1:0];
    par = ^word_i;
  end

  always_comb begin
    fix = 1'b0;
    if (!par && syn == '0)          status_o = ST_OK;
    else if (par && syn == '0)      status_o = ST_FIXED;
    else if (par && syn <= HAM_MAX) begin
      status_o = ST_FIXED;
      fix      = 1'b1;
    end
    else                            status_o = ST_BAD;
  end

  // flip the data bit the syndrome points at; check-bit hits leave data alone
  always_comb begin
    int j;
    data_o = word_i[DATA_W-1:0];
    j = 0;
    for (int p = 1; p <= HAM_N; p++) begin
      if (!is_pow2(p)) begin
        if (fix && syn == p[PAR_W-1:0]) data_o[j] = ~word_i[j];
        j++;
      end
    end
  end
endmodule

// File: rtl/prf_vote.sv
module prf_vote
  import prf_pkg::*;
(
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] c_i,
  output logic [DATA_W-1:0] maj_o,
  output status_e           status_o
);
  logic eq_ab, eq_bc, eq_ac;

  assign maj_o = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
  assign eq_ab = (a_i == b_i);
  assign eq_bc = (b_i == c_i);
  assign eq_ac = (a_i == c_i);

  always_comb begin
    if (eq_ab && eq_bc)              status_o = ST_OK;
    else if (eq_ab || eq_bc || eq_ac) status_o = ST_FIXED;
    else                              status_o = ST_BAD;
  end
endmodule

// File: rtl/prf_store.sv
module prf_store
  import prf_pkg::*;
(
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic [NUM_COPIES-1:0]               we_i,
  input  logic [NUM_COPIES-1:0][SLOT_W-1:0]   slot_i,
  input  logic [CODE_W-1:0]                   wword_i,
  output logic [NUM_COPIES-1:0][CODE_W-1:0]   rword_o,
  input  logic                                inj_en_i,
  input  logic [SLOT_W-1:0]                   inj_slot_i,
  input  logic [CODE_W-1:0]                   inj_mask_i
);
  logic [CODE_W-1:0]    mem [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] hit;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    always_comb begin
      hit[s] = 1'b0;
      for (int c = 0; c < NUM_COPIES; c++)
        if (we_i[c] && slot_i[c] == SLOT_W'(s)) hit[s] = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                         mem[s] <= '0;
      else if (hit[s])                                     mem[s] <= wword_i;
      else if (inj_en_i && inj_slot_i == SLOT_W'(s))       mem[s] <= mem[s] ^ inj_mask_i;
    end

    a_r12_inject_flips: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (inj_en_i && inj_slot_i == SLOT_W'(s) && !hit[s]) |=> mem[s] == ($past(mem[s]) ^ $past(inj_mask_i)));
    a_r12_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit[s] |=> mem[s] == $past(wword_i));
  end

  for (genvar c = 0; c < NUM_COPIES; c++) begin : g_rd
    assign rword_o[c] = mem[slot_i[c]];
  end
endmodule

// File: rtl/prot_regfile.sv
module prot_regfile
  import prf_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic                rd_i,
  input  logic [SLOT_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic [2:0]          mode_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic [1:0]          status_o,
  output logic                ready_o,
  input  logic                inj_en_i,
  input  logic [SLOT_W-1:0]   inj_slot_i,
  input  logic [CODE_W-1:0]   inj_mask_i
);
  localparam int TMR_IDX_W = SLOT_W - 2;
  localparam int SHD_IDX_W = SLOT_W - 1;
  localparam logic [SLOT_W-1:0] TMR_STEP = SLOT_W'(1 << TMR_IDX_W);
  localparam logic [SLOT_W-1:0] SHD_STEP = SLOT_W'(1 << SHD_IDX_W);

  logic                              ready_q;
  logic                              acc_wr, acc_rd, multi;
  logic [NUM_COPIES-1:0]             used;
  logic [NUM_COPIES-1:0][SLOT_W-1:0] slots;
  logic [CODE_W-1:0]                 wword;
  logic [NUM_COPIES-1:0][CODE_W-1:0] rword;
  logic [DATA_W-1:0]                 dec_data, maj_data, rd_data;
  status_e                           dec_st, vote_st, rd_st;
  logic [DATA_W-1:0]                 rdata_q;
  status_e                           status_q;
  logic                              shd_mism, eshd_mism;

  assign acc_wr = wr_i & ready_q;
  assign acc_rd = rd_i & ready_q & ~wr_i;

  always_comb begin
    slots = '0;
    case (mode_i)
      MODE_TMR: begin
        slots[0] = SLOT_W'(addr_i[TMR_IDX_W-1:0]);
        slots[1] = slots[0] + TMR_STEP;
        slots[2] = slots[1] + TMR_STEP;
        used     = 3'b111;
      end
      MODE_SHD, MODE_ECC_SHD: begin
        slots[0] = SLOT_W'(addr_i[SHD_IDX_W-1:0]);
        slots[1] = slots[0] + SHD_STEP;
        slots[2] = slots[0];
        used     = 3'b011;
      end
      default: begin
        slots[0] = addr_i;
        slots[1] = addr_i;
        slots[2] = addr_i;
        used     = 3'b001;
      end
    endcase
  end

  assign multi = (used != 3'b001);
  assign wword = (mode_i == MODE_ECC || mode_i == MODE_ECC_SHD) ? secded_enc(wdata_i)
                                                              : CODE_W'(wdata_i);

  prf_store u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (acc_wr ? used : '0),
    .slot_i     (slots),
    .wword_i    (wword),
    .rword_o    (rword),
    .inj_en_i   (inj_en_i),
    .inj_slot_i (inj_slot_i),
    .inj_mask_i (inj_mask_i)
  );

  prf_secded_dec u_dec (
    .word_i   (rword[0]),
    .data_o   (dec_data),
    .status_o (dec_st)
  );

  prf_vote u_vote (
    .a_i      (rword[0][DATA_W-1:0]),
    .b_i      (rword[1][DATA_W-1:0]),
    .c_i      (rword[2][DATA_W-1:0]),
    .maj_o    (maj_data),
    .status_o (vote_st)
  );

  assign shd_mism  = rword[0][DATA_W-1:0] != rword[1][DATA_W-1:0];
  assign eshd_mism = rword[0] != rword[1];

  always_comb begin
    case (mode_i)
      MODE_ECC: begin
        rd_data = dec_data;
        rd_st   = dec_st;
      end
      MODE_TMR: begin
        rd_data = maj_data;
        rd_st   = vote_st;
      end
      MODE_ECC_SHD: begin
        rd_data = dec_data;
        if (dec_st == ST_BAD) rd_st = ST_BAD;
        else if (eshd_mism)   rd_st = ST_FIXED;
        else                  rd_st = dec_st;
      end
      MODE_SHD: begin
        rd_data = rword[0][DATA_W-1:0];
        rd_st   = shd_mism ? ST_BAD : ST_OK;
      end
      default: begin
        rd_data = rword[0][DATA_W-1:0];
        rd_st   = ST_OK;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      status_q <= ST_OK;
      ready_q  <= 1'b1;
    end else begin
      if (acc_rd) begin
        rdata_q  <= rd_data;
        status_q <= rd_st;
      end
      ready_q <= !(acc_rd || (acc_wr && multi));
    end
  end

  assign rdata_o  = rdata_q;
  assign status_o = status_q;
  assign ready_o  = ready_q;

  a_r1_no_reserved: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o != 2'b11);
  a_r10_busy_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i && ready_o) |=> !ready_o);
  a_r10_busy_after_tmr_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && ready_o && mode_i == MODE_TMR) |=> !ready_o);
  a_r10_ecc_write_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && ready_o && mode_i == MODE_ECC) |=> ready_o);
  a_r10_busy_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |=> ready_o);
  a_r11_hold_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |=> ($stable(rdata_o) && $stable(status_o)));
  a_r9_raw_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_rd && mode_i == MODE_RAW) |=> status_o == 2'b00);
  a_r7_shadow_detect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_rd && mode_i == MODE_SHD && shd_mism) |=> status_o == 2'b10);
  a_r6_tmr_split: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_rd && mode_i == MODE_TMR && rword[0][DATA_W-1:0] != rword[1][DATA_W-1:0]
     && rword[1][DATA_W-1:0] != rword[2][DATA_W-1:0]
     && rword[0][DATA_W-1:0] != rword[2][DATA_W-1:0]) |=> status_o == 2'b10);
endmodule

// File: tb/prot_regfile_bench.sv
`timescale 1ns/1ps
module prot_regfile_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_i = 1'b0, rd_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [2:0]  mode_i = '0;
  logic [31:0] rdata_o;
  logic [1:0]  status_o;
  logic        ready_o;
  logic        inj_en_i = 1'b0;
  logic [4:0]  inj_slot_i = '0;
  logic [38:0] inj_mask_i = '0;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] rd_val;
  logic [1:0]  rd_st;
  logic        rd_rdy;
  logic [31:0] model [32];

  always #2 clk = ~clk;

  prot_regfile u_prot_regfile (
    .clk_i(clk), .rst_ni(rst_ni), .wr_i(wr_i), .rd_i(rd_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .mode_i(mode_i), .rdata_o(rdata_o), .status_o(status_o),
    .ready_o(ready_o), .inj_en_i(inj_en_i), .inj_slot_i(inj_slot_i), .inj_mask_i(inj_mask_i)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_ready();
    while (!ready_o) @(negedge clk);
  endtask

  task automatic wr_op(logic [2:0] m, logic [4:0] a, logic [31:0] d);
    wait_ready();
    wr_i = 1; mode_i = m; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_i = 0;
  endtask

  task automatic rd_op(logic [2:0] m, logic [4:0] a);
    wait_ready();
    rd_i = 1; mode_i = m; addr_i = a;
    @(negedge clk);
    rd_i = 0;
    rd_val = rdata_o; rd_st = status_o; rd_rdy = ready_o;
  endtask

  task automatic inject(logic [4:0] s, logic [38:0] m);
    inj_en_i = 1; inj_slot_i = s; inj_mask_i = m;
    @(negedge clk);
    inj_en_i = 0; inj_mask_i = '0;
  endtask

  task automatic rd_chk(string tag, logic [2:0] m, logic [4:0] a, logic [31:0] d, logic [1:0] st);
    rd_op(m, a);
    chk({tag, " data"}, rd_val, d);
    chk({tag, " status"}, {30'd0, rd_st}, {30'd0, st});
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1
    chk("R1 rdata", rdata_o, 32'd0);
    chk("R1 status", {30'd0, status_o}, 32'd0);
    chk("R1 ready", {31'd0, ready_o}, 32'd1);
    rd_chk("R1 ecc zero", 3'b000, 5'd5, 32'd0, 2'b00);

    // R2, R10 single-slot write keeps ready
    wr_op(3'b000, 5'd3, 32'hA5A5_1234);
    chk("R10 ready after ecc write", {31'd0, ready_o}, 32'd1);
    rd_chk("R2 ecc clean", 3'b000, 5'd3, 32'hA5A5_1234, 2'b00);
    chk("R10 ready after read", {31'd0, rd_rdy}, 32'd0);
    // R3
    inject(5'd3, 39'd1 << 7);
    rd_chk("R3 data flip", 3'b000, 5'd3, 32'hA5A5_1234, 2'b01);
    wr_op(3'b000, 5'd3, 32'hA5A5_1234);
    inject(5'd3, 39'd1 << 35);
    rd_chk("R3 check flip", 3'b000, 5'd3, 32'hA5A5_1234, 2'b01);
    wr_op(3'b000, 5'd3, 32'hA5A5_1234);
    inject(5'd3, 39'd1 << 38);
    rd_chk("R3 parity flip", 3'b000, 5'd3, 32'hA5A5_1234, 2'b01);
    // R4
    wr_op(3'b000, 5'd4, 32'h0F0F_F0F0);
    inject(5'd4, (39'd1 << 2) | (39'd1 << 20));
    rd_chk("R4 two data", 3'b000, 5'd4, 32'h0F0F_F0F0 ^ 32'h0010_0004, 2'b10);
    wr_op(3'b000, 5'd4, 32'h0F0F_F0F0);
    inject(5'd4, (39'd1 << 5) | (39'd1 << 33));
    rd_chk("R4 data+check", 3'b000, 5'd4, 32'h0F0F_F0F0 ^ 32'h20, 2'b10);

    // R5 triple mapping, aliasing, busy after write
    wr_op(3'b001, 5'b11010, 32'hCAFE_0001);
    chk("R10 ready after tmr write", {31'd0, ready_o}, 32'd0);
    rd_chk("R5 tmr clean", 3'b001, 5'd2, 32'hCAFE_0001, 2'b00);
    rd_chk("R5 copy slot 10", 3'b100, 5'd10, 32'hCAFE_0001, 2'b00);
    rd_chk("R5 copy slot 18", 3'b100, 5'd18, 32'hCAFE_0001, 2'b00);
    inject(5'd10, 39'd1);
    rd_chk("R5 one copy bad", 3'b001, 5'd2, 32'hCAFE_0001, 2'b01);
    // R6
    inject(5'd18, 39'd1 << 5);
    rd_chk("R6 no agreement", 3'b001, 5'd2, 32'hCAFE_0001, 2'b10);

    // R7 plain shadow
    wr_op(3'b011, 5'd17, 32'h1357_9BDF);
    rd_chk("R7 shadow clean", 3'b011, 5'd1, 32'h1357_9BDF, 2'b00);
    rd_chk("R7 copy slot 17", 3'b100, 5'd17, 32'h1357_9BDF, 2'b00);
    inject(5'd17, 39'd1 << 3);
    rd_chk("R7 copy bad", 3'b011, 5'd1, 32'h1357_9BDF, 2'b10);
    wr_op(3'b011, 5'd1, 32'h1357_9BDF);
    inject(5'd1, 39'd1 << 3);
    rd_chk("R7 primary bad", 3'b011, 5'd1, 32'h1357_9BDF ^ 32'h8, 2'b10);

    // R8 ECC shadow
    wr_op(3'b010, 5'd6, 32'h7777_0000);
    rd_chk("R8 clean", 3'b010, 5'd6, 32'h7777_0000, 2'b00);
    inject(5'd22, 39'd1 << 1);
    rd_chk("R8 shadow differs", 3'b010, 5'd6, 32'h7777_0000, 2'b01);
    inject(5'd6, 39'd1 << 9);
    rd_chk("R8 corrected+differ", 3'b010, 5'd6, 32'h7777_0000, 2'b01);
    wr_op(3'b010, 5'd6, 32'h7777_0000);
    inject(5'd6, 39'd6);
    rd_chk("R8 double", 3'b010, 5'd6, 32'h7777_0006, 2'b10);
    wr_op(3'b010, 5'd6, 32'h7777_0000);
    inject(5'd6, 39'd1 << 12);
    inject(5'd22, 39'd1 << 12);
    rd_chk("R8 same single both", 3'b010, 5'd6, 32'h7777_0000, 2'b01);

    // R9 raw and unused codes
    wr_op(3'b100, 5'd30, 32'h0000_FFFF);
    inject(5'd30, 39'd1 << 31);
    rd_chk("R9 raw flip", 3'b100, 5'd30, 32'h8000_FFFF, 2'b00);
    wr_op(3'b111, 5'd9, 32'h2468_ACE0);
    rd_chk("R9 code 101", 3'b101, 5'd9, 32'h2468_ACE0, 2'b00);

    // R11 write ignored while busy
    wr_op(3'b001, 5'd3, 32'h1111_1111);
    chk("R11 busy", {31'd0, ready_o}, 32'd0);
    wr_i = 1; mode_i = 3'b100; addr_i = 5'd31; wdata_i = 32'hDEAD_BEEF;
    @(negedge clk);
    wr_i = 0;
    rd_chk("R11 busy write dropped", 3'b100, 5'd31, 32'd0, 2'b00);
    // R11 read ignored while busy
    rd_i = 1; mode_i = 3'b100; addr_i = 5'd9;
    @(negedge clk);
    rd_i = 0;
    chk("R11 busy read dropped", rdata_o, 32'd0);
    // R11 write with read
    wait_ready();
    wr_i = 1; rd_i = 1; mode_i = 3'b100; addr_i = 5'd20; wdata_i = 32'h5555_AAAA;
    @(negedge clk);
    wr_i = 0; rd_i = 0;
    chk("R11 read suppressed", rdata_o, 32'd0);
    chk("R11 ready stays", {31'd0, ready_o}, 32'd1);
    rd_chk("R11 write done", 3'b100, 5'd20, 32'h5555_AAAA, 2'b00);

    // R12 write beats injection
    wait_ready();
    wr_i = 1; mode_i = 3'b100; addr_i = 5'd12; wdata_i = 32'h0BAD_F00D;
    inj_en_i = 1; inj_slot_i = 5'd12; inj_mask_i = '1;
    @(negedge clk);
    wr_i = 0; inj_en_i = 0; inj_mask_i = '0;
    rd_chk("R12 write wins", 3'b100, 5'd12, 32'h0BAD_F00D, 2'b00);
    inject(5'd12, 39'h00_0000_00F0);
    rd_chk("R12 mask applied", 3'b100, 5'd12, 32'h0BAD_F0FD, 2'b00);

    // random traffic per mode (R2 R5 R7 R8 R9)
    for (int m = 0; m < 5; m++) begin
      logic [4:0] msk;
      bit vld [32];
      msk = (m == 1) ? 5'h07 : (m == 2 || m == 3) ? 5'h0F : 5'h1F;
      for (int i = 0; i < 32; i++) vld[i] = 0;
      for (int n = 0; n < 60; n++) begin
        logic [4:0]  a;
        logic [31:0] d;
        a = 5'($urandom);
        d = $urandom;
        if ($urandom % 2 == 0 || !vld[a & msk]) begin
          wr_op(3'(m), a, d);
          model[a & msk] = d;
          vld[a & msk] = 1;
        end else begin
          rd_chk($sformatf("R2 R5 R7 R8 R9 random mode %0d", m), 3'(m), a,
                 model[a & msk], 2'b00);
        end
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule